// File: doc/BRIEF.md
# SDRAM Command Timing Checker

A passive observer for the command bus of a two-bank synchronous DRAM. On every rising clock edge it samples clock enable, chip select, the three command strobes, the bank select and the row/auto-precharge address bit, turns them into one command, and judges that command against the tracked state of both banks. It never drives the memory. It only reports.

Each bank carries three saturating age counters: cycles since its last activate, since its last close, and since its last write data beat. A small burst tracker follows the current column burst. It does this so it knows when write data is on the bus, when an auto-precharge burst closes its bank, and when a burst is cut short. Every rule broken in a cycle sets its own bit in a violation code. The code comes out one cycle later together with a pulse, and a saturating counter totals the cycles that had a violation. All minimum spacings and the burst length are parameters, in clocks.

Top module: `sdcmd_guard`

## Requirements
- R1: A cycle is a command only with `cke` high and `cs_n` low. The strobes {ras_n,cas_n,we_n} then decode as: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop, 111 no-op. Any other cycle is a no-op. It changes no bank state and raises no violation.
- R2: A violation in cycle t shows as `viol_pulse` high with `viol_code` in cycle t+1 only. All rules broken in t are set together in the code. `viol_count` grows by one per violating cycle and saturates.
- R3: A read or write to an open bank fewer than TRCD clocks after that bank's activate sets bit 0.
- R4: A precharge that closes an open bank fewer than TRAS clocks after its activate sets bit 1. An activate fewer than TRC clocks after the same bank's previous activate sets bit 2.
- R5: An activate fewer than TRP clocks after the same bank was closed sets bit 3. An activate fewer than TRRD clocks after the other bank's activate sets bit 4.
- R6: A precharge closing an open bank fewer than TRDL clocks after that bank's last write data beat sets bit 5. A read or write fewer than TCDL clocks after any write data beat sets bit 6. A write puts data on the bus from its command cycle for BURST_LEN cycles. Another column command, a burst stop, or a precharge of the burst's bank cuts the burst off, and no beat occurs in that cycle.
- R7: A refresh or mode set while either bank is open sets bit 7.
- R8: Any command fewer than TMRD clocks after a mode set sets bit 8.
- R9: A precharge with `a10` high closes both banks and ignores `ba`. With `a10` low it closes only bank `ba` (0 or 1).
- R10: A read or write with `a10` high sets auto-precharge. A read or write to that bank while the burst runs sets bit 10. The bank closes after the burst's last beat, or in the cycle a column command cuts the burst off. Its close age counts from the following cycle, so activate is legal TRP clocks after that cycle.
- R11: A read or write to a closed bank sets bit 9. An activate to an open bank sets bit 11.
- R12: The code is one-hot per rule: bit 0 RCD, 1 RAS, 2 RC, 3 RP, 4 RRD, 5 RDL, 6 CDL, 7 banks-not-idle, 8 mode-set gap, 9 closed bank, 10 auto-precharge busy, 11 reopen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 1 | Bank select |
| a10 | input | 1 | Precharge-all / auto-precharge address bit |
| viol_pulse | output | 1 | High for one cycle after a violating command |
| viol_code | output | 12 | One-hot-per-rule violation bits |
| viol_count | output | CNT_W | Saturating count of violating cycles |

## Verification
Some properties are checked on every cycle. Deselected and clock-disabled cycles never yield a violation. The counter moves exactly with the pulse. A command right after a mode set raises the gap bit. A column command right after an activate on the same bank raises the RCD bit. The other rules depend on bank history, so only the bench's scripted sequences can show them: closing a single bank versus both, write recovery measured from a truncated burst, the auto-precharge closing point, and several rules broken in one cycle. Each of these sequences is checked against expected codes placed cycle by cycle in a scoreboard.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   typedef enum logic [2:0] {
      C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST
   } cmd_e;

   localparam int NVIOL   = 12;
   localparam int V_RCD   = 0;
   localparam int V_RAS   = 1;
   localparam int V_RC    = 2;
   localparam int V_RP    = 3;
   localparam int V_RRD   = 4;
   localparam int V_RDL   = 5;
   localparam int V_CDL   = 6;
   localparam int V_BUSY  = 7;
   localparam int V_MRD   = 8;
   localparam int V_NOROW = 9;
   localparam int V_APB   = 10;
   localparam int V_REOP  = 11;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdcmd_age.sv
// Saturating "cycles since event" counter; reset value means long ago.
module sdcmd_age #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   input  logic         clr,
   output logic [W-1:0] age
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '1;
      else if (hit)        age <= W'(1);
      else if (clr)        age <= '0;
      else if (age != '1)  age <= age + 1'b1;
   end
endmodule

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
   import sdcmd_pkg::*;
(
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);
   always_comb begin
      cmd = C_NOP;
      if (cke && !cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = C_ACT;
            3'b101:  cmd = C_RD;
            3'b100:  cmd = C_WR;
            3'b010:  cmd = C_PRE;
            3'b001:  cmd = C_REF;
            3'b000:  cmd = C_MRS;
            3'b110:  cmd = C_BST;
            default: cmd = C_NOP;
         endcase
      end
   end
endmodule

// File: rtl/sdcmd_burst.sv
// Tracks the running column burst: write beats, auto-precharge close, truncation.
module sdcmd_burst #(
   parameter int BL = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       col_go,
   input  logic       col_bank,
   input  logic       col_wr,
   input  logic       col_ap,
   input  logic       bst,
   input  logic [1:0] pre_hit,
   output logic [1:0] wbeat,
   output logic [1:0] ap_fire,
   output logic [1:0] ap_busy
);
   localparam int BW = $clog2(BL + 1);
   localparam logic [BW-1:0] BL_M1 = BW'(BL - 1);

   logic [BW-1:0] rem_q;
   logic          bank_q, wr_q, ap_q;
   logic          running, cut, cont, last_cont, single_ap;

   assign running   = (rem_q != '0);
   assign cut       = running && (col_go || bst || pre_hit[bank_q]);
   assign cont      = running && !cut;
   assign last_cont = cont && (rem_q == BW'(1));

   generate
      if (BL == 1) begin : g_single
         assign single_ap = col_go && col_ap;
      end else begin : g_multi
         assign single_ap = 1'b0;
      end
   endgenerate

   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank_out
         assign wbeat[b]   = (col_go && col_wr && (col_bank == 1'(b))) ||
                             (cont && wr_q && (bank_q == 1'(b)));
         assign ap_fire[b] = (running && ap_q && (bank_q == 1'(b)) && (last_cont || cut)) ||
                             (single_ap && (col_bank == 1'(b)));
         assign ap_busy[b] = running && ap_q && (bank_q == 1'(b));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         bank_q <= 1'b0;
         wr_q   <= 1'b0;
         ap_q   <= 1'b0;
      end else if (col_go) begin
         rem_q  <= BL_M1;
         bank_q <= col_bank;
         wr_q   <= col_wr;
         ap_q   <= col_ap;
      end else if (cut) begin
         rem_q  <= '0;
      end else if (running) begin
         rem_q  <= rem_q - 1'b1;
      end
   end
endmodule

// File: rtl/sdcmd_bank.sv
// Per-bank open flag and age counters.
module sdcmd_bank #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         act_hit,
   input  logic         pre_hit,
   input  logic         ap_close,
   input  logic         wbeat,
   output logic         is_open,
   output logic [W-1:0] act_age,
   output logic [W-1:0] pre_age,
   output logic [W-1:0] wr_age
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    is_open <= 1'b0;
      else if (act_hit)              is_open <= 1'b1;
      else if (pre_hit || ap_close)  is_open <= 1'b0;
   end

   sdcmd_age #(.W(W)) u_act (.clk(clk), .rst_n(rst_n), .hit(act_hit), .clr(1'b0), .age(act_age));
   sdcmd_age #(.W(W)) u_pre (.clk(clk), .rst_n(rst_n), .hit(pre_hit),
                             .clr(ap_close && !act_hit), .age(pre_age));
   sdcmd_age #(.W(W)) u_wr  (.clk(clk), .rst_n(rst_n), .hit(wbeat), .clr(1'b0), .age(wr_age));
endmodule

// File: rtl/sdcmd_guard.sv
module sdcmd_guard
   import sdcmd_pkg::*;
#(
   parameter int TRCD      = 3,
   parameter int TRAS      = 6,
   parameter int TRC       = 9,
   parameter int TRP       = 3,
   parameter int TRRD      = 2,
   parameter int TRDL      = 2,
   parameter int TCDL      = 1,
   parameter int TMRD      = 2,
   parameter int BURST_LEN = 4,
   parameter int CNT_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic             ba,
   input  logic             a10,
   output logic             viol_pulse,
   output logic [11:0]      viol_code,
   output logic [CNT_W-1:0] viol_count
);
   localparam int TMAX = max2(max2(max2(TRCD, TRAS), max2(TRC, TRP)),
                              max2(max2(TRRD, TRDL), max2(TCDL, TMRD)));
   localparam int AW   = $clog2(TMAX + 1);
   localparam logic [AW-1:0] L_RCD = AW'(TRCD);
   localparam logic [AW-1:0] L_RAS = AW'(TRAS);
   localparam logic [AW-1:0] L_RC  = AW'(TRC);
   localparam logic [AW-1:0] L_RP  = AW'(TRP);
   localparam logic [AW-1:0] L_RRD = AW'(TRRD);
   localparam logic [AW-1:0] L_RDL = AW'(TRDL);
   localparam logic [AW-1:0] L_CDL = AW'(TCDL);
   localparam logic [AW-1:0] L_MRD = AW'(TMRD);

   initial begin : g_param_chk
      assert (TRCD >= 1 && TRAS >= 1 && TRC >= 1 && TRP >= 1)
         else $error("row timings must be at least one clock");
      assert (TRRD >= 1 && TRDL >= 1 && TCDL >= 1 && TMRD >= 1)
         else $error("spacing timings must be at least one clock");
      assert (BURST_LEN >= 1 && CNT_W >= 1)
         else $error("burst length and counter width must be positive");
   end

   cmd_e cmd;
   logic is_col;
   logic [1:0] act_hit, pre_hit, wbeat, ap_fire, ap_busy, open;
   logic [AW-1:0] act_age [2];
   logic [AW-1:0] pre_age [2];
   logic [AW-1:0] wr_age  [2];
   logic [AW-1:0] mrd_age;
   logic [NVIOL-1:0] v;

   sdcmd_decode u_dec (.cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
                       .we_n(we_n), .cmd(cmd));

   assign is_col = (cmd == C_RD) || (cmd == C_WR);

   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         assign act_hit[b] = (cmd == C_ACT) && (ba == 1'(b));
         assign pre_hit[b] = (cmd == C_PRE) && (a10 || (ba == 1'(b)));
         sdcmd_bank #(.W(AW)) u_bank (
            .clk(clk), .rst_n(rst_n), .act_hit(act_hit[b]), .pre_hit(pre_hit[b]),
            .ap_close(ap_fire[b]), .wbeat(wbeat[b]), .is_open(open[b]),
            .act_age(act_age[b]), .pre_age(pre_age[b]), .wr_age(wr_age[b]));
      end
   endgenerate

   sdcmd_burst #(.BL(BURST_LEN)) u_burst (
      .clk(clk), .rst_n(rst_n), .col_go(is_col), .col_bank(ba),
      .col_wr(cmd == C_WR), .col_ap(a10), .bst(cmd == C_BST),
      .pre_hit(pre_hit), .wbeat(wbeat), .ap_fire(ap_fire), .ap_busy(ap_busy));

   sdcmd_age #(.W(AW)) u_mrd (.clk(clk), .rst_n(rst_n), .hit(cmd == C_MRS),
                              .clr(1'b0), .age(mrd_age));

   always_comb begin
      v          = '0;
      v[V_RCD]   = is_col && open[ba] && (act_age[ba] < L_RCD);
      v[V_NOROW] = is_col && !open[ba];
      v[V_APB]   = is_col && ap_busy[ba];
      v[V_CDL]   = is_col && ((wr_age[0] < L_CDL) || (wr_age[1] < L_CDL));
      for (int b = 0; b < 2; b++) begin
         if (pre_hit[b] && open[b] && (act_age[b] < L_RAS)) v[V_RAS] = 1'b1;
         if (pre_hit[b] && open[b] && (wr_age[b]  < L_RDL)) v[V_RDL] = 1'b1;
      end
      v[V_RC]    = (cmd == C_ACT) && (act_age[ba] < L_RC);
      v[V_RP]    = (cmd == C_ACT) && (pre_age[ba] < L_RP);
      v[V_RRD]   = (cmd == C_ACT) && (act_age[~ba] < L_RRD);
      v[V_REOP]  = (cmd == C_ACT) && open[ba];
      v[V_BUSY]  = ((cmd == C_MRS) || (cmd == C_REF)) && (|open);
      v[V_MRD]   = (cmd != C_NOP) && (mrd_age < L_MRD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_pulse <= 1'b0;
         viol_code  <= '0;
         viol_count <= '0;
      end else begin
         viol_pulse <= |v;
         viol_code  <= v;
         if ((|v) && (viol_count != '1)) viol_count <= viol_count + 1'b1;
      end
   end
endmodule

// File: rtl/sdcmd_guard_chk.sv
module sdcmd_guard_chk #(
   parameter int TRCD  = 3,
   parameter int TMRD  = 2,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cke,
   input logic             cs_n,
   input logic             ras_n,
   input logic             cas_n,
   input logic             we_n,
   input logic             ba,
   input logic             viol_pulse,
   input logic [11:0]      viol_code,
   input logic [CNT_W-1:0] viol_count
);
   logic is_mrs, is_cmd, is_act, is_col;
   assign is_cmd = cke && !cs_n && !(ras_n && cas_n && we_n);
   assign is_mrs = cke && !cs_n && !ras_n && !cas_n && !we_n;
   assign is_act = cke && !cs_n && !ras_n && cas_n && we_n;
   assign is_col = cke && !cs_n && ras_n && !cas_n;

   // R1: deselected or clock-disabled cycles never report
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || !cke) |=> (!viol_pulse && viol_code == '0));

   // R2: counter steps by one with each pulse
   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_pulse && $past(viol_count) != '1) |-> viol_count == $past(viol_count) + 1'b1);

   // R2: counter holds without a pulse
   p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !viol_pulse |-> $stable(viol_count));

   // R8: command right after a mode set flags the gap bit
   p_mrs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((TMRD > 1) && is_mrs) ##1 is_cmd |=> viol_code[8]);

   // R3: column right after activate on the same bank flags RCD
   p_rcd_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((TRCD > 1) && is_act) ##1 (is_col && ba == $past(ba)) |=> viol_code[0]);
endmodule

bind sdcmd_guard sdcmd_guard_chk #(.TRCD(TRCD), .TMRD(TMRD), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sdcmd_guard_test.sv
`timescale 1ns/1ps
module sdcmd_guard_test;
   localparam logic [11:0] B_RCD = 12'h001, B_RAS = 12'h002, B_RC = 12'h004,
                           B_RP = 12'h008, B_RRD = 12'h010, B_RDL = 12'h020,
                           B_BUSY = 12'h080, B_MRD = 12'h100,
                           B_NOROW = 12'h200, B_APB = 12'h400, B_REOP = 12'h800;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic ba = 1'b0, a10 = 1'b0;
   logic viol_pulse;
   logic [11:0] viol_code;
   logic [15:0] viol_count;

   int checks = 0, errors = 0, exp_cnt = 0;
   bit done = 0;

   typedef struct { logic [11:0] code; string tag; } exp_t;
   exp_t sbq[$];

   always #2 clk = ~clk;

   sdcmd_guard uut (.clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
                    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
                    .viol_pulse(viol_pulse), .viol_code(viol_code), .viol_count(viol_count));

   task automatic drive(input logic k, input logic c, input logic r, input logic ca,
                        input logic w, input logic b, input logic ap,
                        input logic [11:0] e, input string t);
      @(negedge clk);
      cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; a10 = ap;
      sbq.push_back('{e, t});
   endtask

   task automatic act(input logic b, input logic [11:0] e, input string t);
      drive(1, 0, 0, 1, 1, b, 0, e, t); endtask
   task automatic rd(input logic b, input logic ap, input logic [11:0] e, input string t);
      drive(1, 0, 1, 0, 1, b, ap, e, t); endtask
   task automatic wr(input logic b, input logic ap, input logic [11:0] e, input string t);
      drive(1, 0, 1, 0, 0, b, ap, e, t); endtask
   task automatic pre(input logic b, input logic ap, input logic [11:0] e, input string t);
      drive(1, 0, 0, 1, 0, b, ap, e, t); endtask
   task automatic refr(input logic [11:0] e, input string t);
      drive(1, 0, 0, 0, 1, 0, 0, e, t); endtask
   task automatic mrs(input logic [11:0] e, input string t);
      drive(1, 0, 0, 0, 0, 0, 0, e, t); endtask
   task automatic nop(input int n);
      for (int i = 0; i < n; i++) drive(1, 1, 1, 1, 1, 0, 0, '0, "R1 idle");
   endtask

   // monitor: compare one expected item per cycle, away from the edge
   always begin : monitor
      exp_t e;
      @(posedge clk);
      #1;
      if (rst_n && sbq.size() != 0) begin
         e = sbq.pop_front();
         if (e.code != '0) exp_cnt++;
         checks++;
         if (viol_code !== e.code || viol_pulse !== (e.code != '0) || viol_count !== 16'(exp_cnt)) begin
            errors++;
            $display("FAIL %s: code=%h pulse=%b count=%0d expected code=%h pulse=%b count=%0d",
                     e.tag, viol_code, viol_pulse, viol_count, e.code, (e.code != '0), exp_cnt);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (viol_pulse !== 1'b0 || viol_code !== '0 || viol_count !== '0) begin
         errors++;
         $display("FAIL R2 reset: pulse=%b code=%h count=%0d expected 0 0 0",
                  viol_pulse, viol_code, viol_count);
      end
      @(negedge clk); rst_n = 1'b1;

      drive(1, 1, 0, 0, 0, 0, 0, '0, "R1 deselected mode set ignored");
      drive(0, 0, 0, 1, 1, 0, 0, '0, "R1 clock-disabled activate ignored");
      rd(0, 0, B_NOROW, "R1 R11 bank still closed after ignored activate");
      nop(5);
      act(0, '0, "R3 activate");
      rd(0, 0, B_RCD, "R3 read one clock after activate");
      nop(1);
      rd(0, 0, '0, "R3 read at TRCD");
      act(0, B_REOP | B_RC, "R11 R4 activate of open bank");
      nop(3);
      pre(0, 0, B_RAS, "R4 precharge before TRAS");
      act(0, B_RP | B_RC, "R5 R4 activate before TRP and TRC");
      act(1, B_RRD, "R5 other bank before TRRD");
      nop(1);
      pre(0, 1, B_RAS, "R9 precharge-all hits both young banks");
      nop(10);
      refr('0, "R9 R7 refresh after precharge-all");
      nop(2);
      act(0, '0, "R5 activate bank 0");
      nop(1);
      act(1, '0, "R5 other bank at TRRD");
      nop(9);
      pre(1, 0, '0, "R9 single-bank precharge");
      refr(B_BUSY, "R9 R7 refresh with bank 0 open");
      rd(1, 0, B_NOROW, "R9 bank 1 closed");
      mrs(B_BUSY, "R7 mode set with bank open");
      rd(0, 0, B_MRD, "R8 read right after mode set");
      pre(0, 0, '0, "R8 precharge at TMRD");
      nop(1);
      mrs('0, "R7 mode set with both idle");
      nop(1);
      act(0, '0, "R8 activate at TMRD");
      nop(2);
      wr(0, 0, '0, "R6 write");
      nop(1);
      wr(0, 0, '0, "R6 column one clock after write data at TCDL");
      nop(1);
      pre(0, 0, B_RDL, "R6 precharge one clock after write data");
      nop(3);
      act(0, '0, "R6 reopen");
      nop(2);
      wr(0, 0, '0, "R6 full write burst");
      nop(4);
      pre(0, 0, '0, "R6 precharge at TRDL");
      nop(3);
      act(0, '0, "R10 reopen");
      nop(2);
      rd(0, 1, '0, "R10 read with auto-precharge");
      nop(1);
      rd(0, 0, B_APB, "R10 read during auto-precharge burst");
      nop(2);
      rd(0, 0, B_NOROW, "R10 bank closed by cut auto-precharge");
      act(0, '0, "R10 activate TRP after auto close");
      nop(2);
      wr(0, 1, '0, "R10 write with auto-precharge");
      nop(3);
      rd(0, 0, B_NOROW, "R10 bank closed after last beat");
      nop(1);
      act(0, B_RP, "R10 activate one clock before TRP");
      act(1, B_RRD, "R5 other bank too soon");
      act(1, B_REOP | B_RC, "R2 R12 two rules in one cycle");
      mrs(B_BUSY, "R7 mode set with banks open");
      mrs(B_BUSY | B_MRD, "R2 R8 mode set gap and busy together");
      nop(3);
      @(posedge clk); #2;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule